// File: doc/BRIEF.md
# Sub-cycle two-channel coincidence counter

This block counts coincidences between rising edges on two independent channels, A and B, with a time resolution finer than one clock period. Each edge reaches the block as a timestamp: a coarse count of clock cycles plus a fine count of delay-line taps that were already high at the sampling edge. More high taps means the edge came earlier in that cycle. The two fine counts share one tap spacing, so they compare directly. Another block produces the timestamps, and the tap widths are assumed to be calibrated already.

Each channel's timestamp arrives on a valid/ready stream. A channel holds at most one edge that has not yet been matched. While that edge is held, the channel's ready is low, and a source that keeps valid high is not served until the slot frees. A transfer takes place only in a cycle where valid and ready are both high. A held edge waits a bounded number of cycles for a partner on the other channel. A pair whose arrival times differ by no more than the window (in taps) counts as a coincidence. Edges that find no partner in time, or whose partner is too far away, count as singles on their own channel.

Top module: `coinc_counter`

## Requirements
- R1: The arrival time of an edge, in taps, is coarse × TAPS − fine, with TAPS = 10 taps per clock cycle. Two edges are coincident when the absolute difference of their arrival times is at most `window`. With window 4 and equal coarse counts, fine counts 3 and 4 are coincident, and 3 and 9 are not.
- R2: Edges accepted in different cycles are compared on their combined arrival times. A at coarse 10, fine 1 and B one cycle later at coarse 11, fine 8 are 3 taps apart and coincide under window 4.
- R3: When A and B are both accepted in the same cycle, they are compared in that cycle and both are consumed. A mismatch adds one to each singles counter.
- R4: A held edge with no partner is dropped and counted as a single at the end of the second cycle after it was accepted. Its channel's ready goes high again in the next cycle.
- R5: `a_ready` (or `b_ready`) is low exactly while that channel holds an unmatched edge. A `valid` raised while ready is low is not taken.
- R6: A held edge is compared with an edge accepted on the other channel in either of the two following cycles, and both are consumed. A mismatch adds one to each singles counter.
- R7: `coinc_pulse` is high for one cycle, in the cycle after each coincidence is decided. This is the same cycle in which `coinc_cnt` shows the increment.
- R8: All three counters saturate at their all-ones value instead of wrapping.
- R9: A high `clear` sets all three counters to zero on the next clock edge. It overrides any increment decided in the same cycle and leaves held edges and `coinc_pulse` untouched.
- R10: `window` is used as it stands in the cycle the comparison is made, not as it stood when a held edge was accepted. Window 0 accepts only equal arrival times.
- R11: After reset the counters are zero, `coinc_pulse` is low and both ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous counter clear |
| window | input | WIN_W | Coincidence window in taps |
| a_valid | input | 1 | Channel A timestamp valid |
| a_ready | output | 1 | Channel A can accept a timestamp |
| a_coarse | input | COARSE_W | Channel A cycle count |
| a_fine | input | FINE_W | Channel A high-tap count |
| b_valid | input | 1 | Channel B timestamp valid |
| b_ready | output | 1 | Channel B can accept a timestamp |
| b_coarse | input | COARSE_W | Channel B cycle count |
| b_fine | input | FINE_W | Channel B high-tap count |
| coinc_pulse | output | 1 | One-cycle pulse per coincidence |
| coinc_cnt | output | CNT_W | Saturating coincidence count |
| single_a_cnt | output | CNT_W | Saturating singles count, channel A |
| single_b_cnt | output | CNT_W | Saturating singles count, channel B |

## Verification
Two pairs of functions can fall in the same cycle. One pair is a counter increment and a clear. The other is an acceptance on both channels at once, set against one channel's held edge meeting a new edge from the other. The bench raises `clear` in the very cycle a same-cycle pair coincides. It expects zeroed counters together with a raised pulse. It also steps a held edge to the last cycle of its wait before the partner arrives. A behavioural reference model tracks held edges, their ages and the saturating counts. The bench compares every output against this model on each clock.

// File: rtl/coinc_pkg.sv
package coinc_pkg;
  typedef enum logic {SLOT_EMPTY, SLOT_HELD} slot_e;
  typedef enum logic [1:0] {CNT_COINC = 2'd0, CNT_SGL_A = 2'd1, CNT_SGL_B = 2'd2} cnt_idx_e;
endpackage

// File: rtl/coinc_slot.sv
module coinc_slot
  import coinc_pkg::*;
#(
  parameter int CW   = 16,
  parameter int FW   = 4,
  parameter int WAIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          store,
  input  logic          take,
  input  logic [CW-1:0] in_coarse,
  input  logic [FW-1:0] in_fine,
  output logic          held,
  output logic [CW-1:0] hold_coarse,
  output logic [FW-1:0] hold_fine,
  output logic          expire
);
  localparam int AW = $clog2(WAIT + 1);

  slot_e         st;
  logic [AW-1:0] age;

  assign held   = (st == SLOT_HELD);
  assign expire = held & ~take & (age == AW'(WAIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= SLOT_EMPTY;
      age         <= '0;
      hold_coarse <= '0;
      hold_fine   <= '0;
    end else if (store) begin
      st          <= SLOT_HELD;
      age         <= '0;
      hold_coarse <= in_coarse;
      hold_fine   <= in_fine;
    end else if (take || expire) begin
      st  <= SLOT_EMPTY;
      age <= '0;
    end else if (held) begin
      age <= age + AW'(1);
    end
  end
endmodule

// File: rtl/coinc_judge.sv
module coinc_judge #(
  parameter int CW   = 16,
  parameter int FW   = 4,
  parameter int WW   = 5,
  parameter int TAPS = 10
) (
  input  logic [CW-1:0] a_coarse,
  input  logic [FW-1:0] a_fine,
  input  logic [CW-1:0] b_coarse,
  input  logic [FW-1:0] b_fine,
  input  logic [WW-1:0] window,
  output logic          hit
);
  localparam int DW = CW + FW + 6;

  logic [CW-1:0]        dc;
  logic signed [DW-1:0] dcs;
  logic signed [DW-1:0] gap;
  logic [DW-1:0]        mag;

  always_comb begin
    // coarse difference taken modulo 2^CW so counter wrap is harmless
    dc  = a_coarse - b_coarse;
    dcs = DW'($signed(dc));
    gap = dcs * DW'(TAPS) - (DW'(a_fine) - DW'(b_fine));
    mag = gap[DW-1] ? DW'(-gap) : DW'(gap);
    hit = (mag <= DW'(window));
  end
endmodule

// File: rtl/coinc_satcnt.sv
module coinc_satcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= '0;
    else if (clr)              count <= '0;
    else if (inc && !(&count)) count <= count + W'(1);
  end
endmodule

// File: rtl/coinc_counter.sv
module coinc_counter
  import coinc_pkg::*;
#(
  parameter int COARSE_W = 16,
  parameter int FINE_W   = 4,
  parameter int TAPS     = 10,
  parameter int WIN_W    = 5,
  parameter int CNT_W    = 32,
  parameter int WAIT_CYC = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic [WIN_W-1:0]    window,
  input  logic                a_valid,
  output logic                a_ready,
  input  logic [COARSE_W-1:0] a_coarse,
  input  logic [FINE_W-1:0]   a_fine,
  input  logic                b_valid,
  output logic                b_ready,
  input  logic [COARSE_W-1:0] b_coarse,
  input  logic [FINE_W-1:0]   b_fine,
  output logic                coinc_pulse,
  output logic [CNT_W-1:0]    coinc_cnt,
  output logic [CNT_W-1:0]    single_a_cnt,
  output logic [CNT_W-1:0]    single_b_cnt
);
  localparam int NCH  = 2;
  localparam int NCNT = 3;

  logic [NCH-1:0]      vld, acc, held, store, take, expire;
  logic [COARSE_W-1:0] crs_in [NCH];
  logic [FINE_W-1:0]   fin_in [NCH];
  logic [COARSE_W-1:0] crs_hd [NCH];
  logic [FINE_W-1:0]   fin_hd [NCH];
  logic [COARSE_W-1:0] crs_op [NCH];
  logic [FINE_W-1:0]   fin_op [NCH];
  logic                do_eval, hit, match, miss;
  logic [NCNT-1:0]     inc;
  logic [CNT_W-1:0]    cnt [NCNT];

  assign vld       = {b_valid, a_valid};
  assign crs_in[0] = a_coarse;
  assign crs_in[1] = b_coarse;
  assign fin_in[0] = a_fine;
  assign fin_in[1] = b_fine;

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      assign acc[c]    = vld[c] & ~held[c];
      assign store[c]  = acc[c] & ~do_eval;
      assign take[c]   = do_eval & held[c];
      assign crs_op[c] = acc[c] ? crs_in[c] : crs_hd[c];
      assign fin_op[c] = acc[c] ? fin_in[c] : fin_hd[c];

      coinc_slot #(.CW(COARSE_W), .FW(FINE_W), .WAIT(WAIT_CYC)) slot_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .store       (store[c]),
        .take        (take[c]),
        .in_coarse   (crs_in[c]),
        .in_fine     (fin_in[c]),
        .held        (held[c]),
        .hold_coarse (crs_hd[c]),
        .hold_fine   (fin_hd[c]),
        .expire      (expire[c])
      );
    end
  endgenerate

  // a comparison needs an operand on each side and at least one fresh edge
  assign do_eval = (acc[0] | held[0]) & (acc[1] | held[1]) & (acc[0] | acc[1]);

  coinc_judge #(.CW(COARSE_W), .FW(FINE_W), .WW(WIN_W), .TAPS(TAPS)) judge_i (
    .a_coarse (crs_op[0]),
    .a_fine   (fin_op[0]),
    .b_coarse (crs_op[1]),
    .b_fine   (fin_op[1]),
    .window   (window),
    .hit      (hit)
  );

  assign match = do_eval & hit;
  assign miss  = do_eval & ~hit;

  assign inc[CNT_COINC] = match;
  assign inc[CNT_SGL_A] = miss | expire[0];
  assign inc[CNT_SGL_B] = miss | expire[1];

  genvar k;
  generate
    for (k = 0; k < NCNT; k++) begin : g_cnt
      coinc_satcnt #(.W(CNT_W)) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clear),
        .inc   (inc[k]),
        .count (cnt[k])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) coinc_pulse <= 1'b0;
    else        coinc_pulse <= match;
  end

  assign a_ready      = ~held[0];
  assign b_ready      = ~held[1];
  assign coinc_cnt    = cnt[CNT_COINC];
  assign single_a_cnt = cnt[CNT_SGL_A];
  assign single_b_cnt = cnt[CNT_SGL_B];
endmodule

// File: rtl/coinc_counter_chk.sv
module coinc_counter_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             a_ready,
  input logic             b_ready,
  input logic             coinc_pulse,
  input logic [CNT_W-1:0] coinc_cnt,
  input logic [CNT_W-1:0] single_a_cnt,
  input logic [CNT_W-1:0] single_b_cnt
);
  // R4: a channel is never blocked for more than two consecutive cycles
  p_wait_limit_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_ready && !$past(a_ready)) |=> a_ready);
  p_wait_limit_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_ready && !$past(b_ready)) |=> b_ready);

  // R9: clear empties every counter on the next edge
  p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (coinc_cnt == '0 && single_a_cnt == '0 && single_b_cnt == '0));

  // R8: a full counter stays full until cleared
  p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((&coinc_cnt) && !clear) |=> (&coinc_cnt));
  p_sat_hold_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((&single_a_cnt) && !clear) |=> (&single_a_cnt));

  // R7: the pulse and the coincidence count move together
  p_pulse_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (coinc_pulse && !$past(clear) && !(&$past(coinc_cnt)))
      |-> (coinc_cnt == $past(coinc_cnt) + CNT_W'(1)));
  p_no_pulse_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!coinc_pulse && !$past(clear)) |-> (coinc_cnt == $past(coinc_cnt)));
endmodule

bind coinc_counter coinc_counter_chk #(.CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .clear        (clear),
  .a_ready      (a_ready),
  .b_ready      (b_ready),
  .coinc_pulse  (coinc_pulse),
  .coinc_cnt    (coinc_cnt),
  .single_a_cnt (single_a_cnt),
  .single_b_cnt (single_b_cnt)
);

// File: tb/coinc_counter_tb.sv
module coinc_counter_tb_top;
  localparam int CW = 16;
  localparam int FW = 4;
  localparam int WW = 5;
  localparam int NW = 4;
  localparam int MAXC = (1 << NW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clear = 1'b0;
  logic [WW-1:0] window = 5'd4;
  logic          a_valid = 1'b0, b_valid = 1'b0;
  logic [CW-1:0] a_coarse = '0, b_coarse = '0;
  logic [FW-1:0] a_fine = '0, b_fine = '0;
  logic          a_ready, b_ready, coinc_pulse;
  logic [NW-1:0] coinc_cnt, single_a_cnt, single_b_cnt;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // reference model state
  bit m_pa, m_pb, m_pulse;
  int m_ta, m_tb, m_agea, m_ageb, m_c, m_sa, m_sb;

  always #5 clk = ~clk;

  coinc_counter #(.COARSE_W(CW), .FINE_W(FW), .TAPS(10), .WIN_W(WW),
                  .CNT_W(NW), .WAIT_CYC(2)) dut_i (
    .clk (clk), .rst_n (rst_n), .clear (clear), .window (window),
    .a_valid (a_valid), .a_ready (a_ready), .a_coarse (a_coarse), .a_fine (a_fine),
    .b_valid (b_valid), .b_ready (b_ready), .b_coarse (b_coarse), .b_fine (b_fine),
    .coinc_pulse (coinc_pulse), .coinc_cnt (coinc_cnt),
    .single_a_cnt (single_a_cnt), .single_b_cnt (single_b_cnt)
  );

  task automatic cmp(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // behavioural model, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pa = 0; m_pb = 0; m_pulse = 0;
      m_c = 0; m_sa = 0; m_sb = 0; m_agea = 0; m_ageb = 0;
    end else begin
      bit acc_a, acc_b, hit, miss, ea, eb, ev;
      int ta, tb, d, x, y;
      acc_a = a_valid && !m_pa;
      acc_b = b_valid && !m_pb;
      ta = int'(a_coarse) * 10 - int'(a_fine);
      tb = int'(b_coarse) * 10 - int'(b_fine);
      hit = 0; miss = 0; ea = 0; eb = 0; ev = 0; x = 0; y = 0;
      if (acc_a && acc_b) begin ev = 1; x = ta; y = tb; end
      else if (acc_a && m_pb) begin ev = 1; x = ta; y = m_tb; m_pb = 0; end
      else if (acc_b && m_pa) begin ev = 1; x = m_ta; y = tb; m_pa = 0; end
      else begin
        if (m_pa) begin if (m_agea == 1) begin m_pa = 0; ea = 1; end else m_agea++; end
        if (m_pb) begin if (m_ageb == 1) begin m_pb = 0; eb = 1; end else m_ageb++; end
        if (acc_a) begin m_pa = 1; m_agea = 0; m_ta = ta; end
        if (acc_b) begin m_pb = 1; m_ageb = 0; m_tb = tb; end
      end
      if (ev) begin
        d = x - y;
        if (d < 0) d = -d;
        if (d <= int'(window)) hit = 1; else miss = 1;
      end
      if (clear) begin m_c = 0; m_sa = 0; m_sb = 0; end
      else begin
        if (hit && m_c < MAXC) m_c++;
        if ((miss || ea) && m_sa < MAXC) m_sa++;
        if ((miss || eb) && m_sb < MAXC) m_sb++;
      end
      m_pulse = hit;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cmp("R5 a_ready vs model", int'(a_ready), int'(!m_pa));
      cmp("R5 b_ready vs model", int'(b_ready), int'(!m_pb));
      cmp("R7 coinc_pulse vs model", int'(coinc_pulse), int'(m_pulse));
      cmp("R1 coinc_cnt vs model", int'(coinc_cnt), m_c);
      cmp("R4 single_a_cnt vs model", int'(single_a_cnt), m_sa);
      cmp("R4 single_b_cnt vs model", int'(single_b_cnt), m_sb);
    end
  end

  task automatic step(input bit av, input int ac, input int af,
                      input bit bv, input int bc, input int bf);
    a_valid = av; a_coarse = CW'(ac); a_fine = FW'(af);
    b_valid = bv; b_coarse = CW'(bc); b_fine = FW'(bf);
    @(negedge clk);
    a_valid = 0; b_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    clear = 1;
    @(negedge clk);
    clear = 0;
  endtask

  task automatic counts(input string tag, input int c, input int sa, input int sb);
    cmp({tag, " coinc"}, int'(coinc_cnt), c);
    cmp({tag, " single A"}, int'(single_a_cnt), sa);
    cmp({tag, " single B"}, int'(single_b_cnt), sb);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    counts("R11 reset", 0, 0, 0);
    cmp("R11 a_ready", int'(a_ready), 1);
    cmp("R11 b_ready", int'(b_ready), 1);
    cmp("R11 pulse", int'(coinc_pulse), 0);

    // R1 / R3 same-cycle comparisons
    window = 4;
    step(1, 5, 3, 1, 5, 4);
    cmp("R1 pulse for 3 vs 4", int'(coinc_pulse), 1);
    step(1, 5, 3, 1, 5, 9);
    counts("R3 3 vs 9", 1, 1, 1);
    cmp("R3 both ready after same-cycle pair", int'(a_ready & b_ready), 1);

    // R2 / R5 adjacent cycles
    do_clear();
    step(1, 10, 1, 0, 0, 0);
    cmp("R5 a_ready low while held", int'(a_ready), 0);
    step(1, 99, 9, 1, 11, 8);
    counts("R2 adjacent cycle pair", 1, 0, 0);
    cmp("R5 a_ready back high", int'(a_ready), 1);

    // R4 lone edge expires
    do_clear();
    step(1, 20, 0, 0, 0, 0);
    idle(1);
    cmp("R4 still held after one wait cycle", int'(a_ready), 0);
    cmp("R4 no single yet", int'(single_a_cnt), 0);
    idle(1);
    cmp("R4 ready after expiry", int'(a_ready), 1);
    counts("R4 expired edge", 0, 1, 0);

    // R6 partner in the last wait cycle, wide window
    do_clear();
    window = 31;
    step(0, 0, 0, 1, 30, 2);
    idle(1);
    step(1, 32, 9, 0, 0, 0);
    counts("R6 late partner", 1, 0, 0);
    window = 4;
    step(1, 40, 0, 0, 0, 0);
    step(0, 0, 0, 1, 41, 0);
    counts("R6 held pair too far", 1, 1, 1);

    // R1 window boundaries and R10 window sampled at evaluation
    do_clear();
    step(1, 50, 2, 1, 50, 6);
    step(1, 50, 1, 1, 50, 6);
    counts("R1 gap equal to and above window", 1, 1, 1);
    window = 0;
    step(1, 50, 5, 1, 50, 5);
    cmp("R10 window zero equal times", int'(coinc_cnt), 2);
    step(1, 60, 3, 0, 0, 0);
    window = 5;
    step(0, 0, 0, 1, 61, 8);
    counts("R10 window taken at evaluation", 3, 1, 1);

    // R9 clear in the same cycle as a coincidence
    window = 4;
    clear = 1;
    step(1, 70, 3, 1, 70, 3);
    clear = 0;
    counts("R9 clear wins over increment", 0, 0, 0);
    cmp("R9 pulse still raised", int'(coinc_pulse), 1);

    // R8 saturation
    for (int i = 0; i < MAXC + 5; i++) step(1, 80 + i, 4, 1, 80 + i, 5);
    counts("R8 saturated", MAXC, 0, 0);
    for (int i = 0; i < MAXC + 3; i++) step(1, 200 + 5 * i, 0, 1, 201 + 5 * i, 0);
    counts("R8 singles saturated", MAXC, MAXC, MAXC);

    idle(3);
    finish_run();
  end
endmodule